// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Least-Recently-Hit Pointer

This block is a fully associative address translation buffer. Each entry maps a virtual page to a physical frame and has its own page size, a power of two from 8 KB to 16 MB. A lookup compares the virtual address against every entry at the same time. The result is registered and appears one cycle after the request.

When no valid entry matches, the block does not walk any page table. It raises a miss trap, and a software handler installs the mapping through a plain write port that takes an entry index and the entry contents.

To choose which entry to overwrite, the handler reads a replacement pointer. Hardware keeps this pointer on the entry that was hit least recently. A flush input drops every mapping at once and returns the pointer to entry 0.

Top module: `tlb_sw_refill`

## Requirements
- R1: A request on `lk_valid` gives `rsp_valid` high exactly one clock later. On a hit, `rsp_hit` is 1 and `rsp_index` is the entry that matched. `rsp_pa` takes its bits above the page offset from that entry's frame field, which is physical address bits [PA_W-1:13], and its page-offset bits from the virtual address.
- R2: A request that matches no valid entry returns `rsp_miss_trap` = 1, `rsp_hit` = 0, `rsp_index` = 0 and `rsp_pa` = 0. Exactly one of hit and miss is high whenever `rsp_valid` is high.
- R3: The size code s selects a page of 2^(13+s) bytes, where code 0 is 8 KB and code 11 is 16 MB. Virtual address bits below 13+s are left out of the compare and pass straight through to the physical address. Codes 12 to 15 behave as code 11.
- R4: A write with `wr_en` loads valid, size, page and frame fields into entry `wr_index` at the clock edge. An entry written with `wr_valid` = 0 never matches.
- R5: When several entries match, the lowest-indexed one supplies `rsp_index` and `rsp_pa`, and `rsp_multi_hit` is 1. With a single match, `rsp_multi_hit` is 0.
- R6: `lru_index` names the entry whose last hit is the oldest. After reset or a flush, the order from least to most recent is 0, 1, ..., N-1. Each hit makes the hit entry the most recent, and this is visible on `lru_index` from the cycle in which the response appears.
- R7: Software writes, misses and idle cycles leave `lru_index` and the recency order unchanged.
- R8: A lookup in the same cycle as a write is judged against the entry contents from before that write.
- R9: `flush` clears every valid bit and restores the reset recency order. A lookup in the flush cycle returns a miss and does not touch the order. A write in the flush cycle is dropped.
- R10: While `rst_n` is low at a clock edge, `rsp_valid` goes to 0, every entry becomes invalid and `lru_index` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Drop all mappings and reset the recency order |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| wr_en | input | 1 | Software entry write |
| wr_index | input | $clog2(N_ENTRIES) | Entry to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_size | input | 4 | Page size code |
| wr_vpn | input | VA_W-13 | Virtual page field |
| wr_pfn | input | PA_W-13 | Physical frame field |
| rsp_valid | output | 1 | Registered lookup result is present |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_miss_trap | output | 1 | No entry matched; software must refill |
| rsp_multi_hit | output | 1 | More than one entry matched |
| rsp_index | output | $clog2(N_ENTRIES) | Winning entry |
| rsp_pa | output | PA_W | Translated physical address |
| lru_index | output | $clog2(N_ENTRIES) | Replacement candidate for the refill routine |

## Verification
A software refill write and a lookup can fall in the same cycle, and so can a flush and a lookup. The bench provokes both. It rewrites an entry in the very cycle a lookup targets that entry, and it issues a lookup together with a flush, and also a write together with a flush. A scoreboard model decides each outcome from the contents the entries held before the edge. A flush always wins: the lookup in that cycle misses, the write is lost, and the replacement pointer shows entry 0.

// File: rtl/tlb_pkg.sv
// Shared constants and helpers for the software-refilled translation buffer.
// Assumes the smallest page is 8 KB and the largest page is 16 MB.
package tlb_pkg;

    localparam int PG_BASE_SHIFT = 13;   // offset bits of the smallest page
    localparam int PG_MAX_CODE   = 11;   // code for a 16 MB page
    localparam int SZ_W          = 4;    // width of the size code

    typedef logic [SZ_W-1:0] pg_size_t;

    // Limit a size code to the largest supported page.
    function automatic pg_size_t clamp_size(input pg_size_t code);
        if (code > pg_size_t'(PG_MAX_CODE))
            return pg_size_t'(PG_MAX_CODE);
        return code;
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
// Register storage for the translation entries.
// Software writes one entry per cycle. A flush clears all valid bits and wins
// over a write in the same cycle. Size codes are clamped when written.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int VPN_W     = 19,
    parameter int PFN_W     = 19,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_valid,
    input  pg_size_t             wr_size,
    input  logic [VPN_W-1:0]     wr_vpn,
    input  logic [PFN_W-1:0]     wr_pfn,
    output logic [N_ENTRIES-1:0] ent_valid,
    output pg_size_t             ent_size [N_ENTRIES],
    output logic [VPN_W-1:0]     ent_vpn  [N_ENTRIES],
    output logic [PFN_W-1:0]     ent_pfn  [N_ENTRIES]
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));

        // Hold one entry: reset or flush clears it, a selected write loads it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[i] <= 1'b0;
                ent_size[i]  <= '0;
                ent_vpn[i]   <= '0;
                ent_pfn[i]   <= '0;
            end else if (flush) begin
                ent_valid[i] <= 1'b0;
            end else if (sel) begin
                ent_valid[i] <= wr_valid;
                ent_size[i]  <= clamp_size(wr_size);
                ent_vpn[i]   <= wr_vpn;
                ent_pfn[i]   <= wr_pfn;
            end
        end
    end

    // R9: after a flush no entry is valid.
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));

    // R4: a write stores its valid bit in the addressed entry.
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (ent_valid[$past(wr_idx)] == $past(wr_valid)));

endmodule

// File: rtl/tlb_match.sv
// Combinational lookup over the registered entries.
// Each entry masks the virtual page bits that lie inside its page. The
// lowest-indexed match wins and more than one match raises the multi flag.
// Assumes VA_W and PA_W are both larger than the largest page offset.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int VPN_W    = VA_W - PG_BASE_SHIFT,
    localparam int PFN_W    = PA_W - PG_BASE_SHIFT
) (
    input  logic [VA_W-1:0]      va,
    input  logic [N_ENTRIES-1:0] ent_valid,
    input  pg_size_t             ent_size [N_ENTRIES],
    input  logic [VPN_W-1:0]     ent_vpn  [N_ENTRIES],
    input  logic [PFN_W-1:0]     ent_pfn  [N_ENTRIES],
    output logic                 any_hit,
    output logic                 multi_hit,
    output logic [IDX_W-1:0]     hit_idx,
    output logic [PA_W-1:0]      pa
);

    logic [N_ENTRIES-1:0] match;
    logic [VPN_W-1:0]     va_vpn;
    logic [PA_W-1:0]      va_low;
    pg_size_t             win_size;
    logic [PFN_W-1:0]     win_pfn;
    logic [PA_W-1:0]      off_mask;

    assign va_vpn = va[VA_W-1:PG_BASE_SHIFT];

    // Bring the virtual address to physical width for the offset pass-through.
    if (PA_W <= VA_W) begin : g_va_trunc
        assign va_low = va[PA_W-1:0];
    end else begin : g_va_ext
        assign va_low = {{(PA_W-VA_W){1'b0}}, va};
    end

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        logic [VPN_W-1:0] keep;
        assign keep     = {VPN_W{1'b1}} << ent_size[i];
        assign match[i] = ent_valid[i] && (((va_vpn ^ ent_vpn[i]) & keep) == '0);
    end

    // Pick the lowest matching index and flag a second match.
    always_comb begin
        any_hit   = 1'b0;
        multi_hit = 1'b0;
        hit_idx   = '0;
        win_size  = '0;
        win_pfn   = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (match[i]) begin
                if (any_hit) begin
                    multi_hit = 1'b1;
                end else begin
                    any_hit  = 1'b1;
                    hit_idx  = IDX_W'(i);
                    win_size = ent_size[i];
                    win_pfn  = ent_pfn[i];
                end
            end
        end
    end

    // Merge the frame bits with the offset bits of the winning page size.
    always_comb begin
        off_mask = ~({PA_W{1'b1}} << (PG_BASE_SHIFT + int'(win_size)));
        if (any_hit)
            pa = ({win_pfn, {PG_BASE_SHIFT{1'b0}}} & ~off_mask) | (va_low & off_mask);
        else
            pa = '0;
    end

endmodule

// File: rtl/tlb_lru_ranks.sv
// Recency tracking: each entry holds a rank, where 0 means most recently hit
// and N-1 means least recently hit. A hit moves its entry to rank 0 and ages
// every entry that was more recent than it. The ranks stay a permutation.
// Reset and flush give entry i the rank N-1-i, which makes entry 0 the
// least recent.
module tlb_lru_ranks #(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    output logic [IDX_W-1:0] lru_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N_ENTRIES - 1);

    logic [IDX_W-1:0] rank [N_ENTRIES];
    logic [IDX_W-1:0] hit_rank;
    int               oldest_cnt;

    assign hit_rank = rank[hit_idx];

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_rank
        // Update one rank on reset, on a flush or on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n || flush)
                rank[i] <= IDX_W'(N_ENTRIES - 1 - i);
            else if (hit_en) begin
                if (hit_idx == IDX_W'(i))
                    rank[i] <= '0;
                else if (rank[i] < hit_rank)
                    rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    // Find the entry that holds the oldest rank and count how many hold it.
    always_comb begin
        lru_idx    = '0;
        oldest_cnt = 0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (rank[i] == OLDEST) begin
                lru_idx    = IDX_W'(i);
                oldest_cnt = oldest_cnt + 1;
            end
        end
    end

    // R6: exactly one entry is the replacement candidate.
    a_r6_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        oldest_cnt == 1);

    // R6: an entry that was just hit is not the replacement candidate.
    a_r6_hit_not_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && !flush && N_ENTRIES > 1) |=> (lru_idx != $past(hit_idx)));

    // R7: without a hit or a flush the candidate does not move.
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_en && !flush) |=> $stable(lru_idx));

    // R9: a flush returns the candidate to entry 0.
    a_r9_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (lru_idx == '0));

endmodule

// File: rtl/tlb_sw_refill.sv
// Top of the software-refilled translation buffer.
// Lookups are combinational over the entry registers, and the result is
// registered one cycle after the request. A miss raises a trap and refills
// come from software through the write port. Only hits move the recency
// order. A flush overrides a lookup and a write in the same cycle.
module tlb_sw_refill
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int VPN_W    = VA_W - PG_BASE_SHIFT,
    localparam int PFN_W    = PA_W - PG_BASE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  logic             wr_valid,
    input  logic [SZ_W-1:0]  wr_size,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss_trap,
    output logic             rsp_multi_hit,
    output logic [IDX_W-1:0] rsp_index,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [IDX_W-1:0] lru_index
);

    logic [N_ENTRIES-1:0] ent_valid;
    pg_size_t             ent_size [N_ENTRIES];
    logic [VPN_W-1:0]     ent_vpn  [N_ENTRIES];
    logic [PFN_W-1:0]     ent_pfn  [N_ENTRIES];
    logic                 m_hit;
    logic                 m_multi;
    logic [IDX_W-1:0]     m_idx;
    logic [PA_W-1:0]      m_pa;
    logic                 use_hit;

    tlb_entry_array #(
        .N_ENTRIES (N_ENTRIES),
        .VPN_W     (VPN_W),
        .PFN_W     (PFN_W)
    ) u_entries (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_idx    (wr_index),
        .wr_valid  (wr_valid),
        .wr_size   (pg_size_t'(wr_size)),
        .wr_vpn    (wr_vpn),
        .wr_pfn    (wr_pfn),
        .ent_valid (ent_valid),
        .ent_size  (ent_size),
        .ent_vpn   (ent_vpn),
        .ent_pfn   (ent_pfn)
    );

    tlb_match #(
        .N_ENTRIES (N_ENTRIES),
        .VA_W      (VA_W),
        .PA_W      (PA_W)
    ) u_match (
        .va        (lk_va),
        .ent_valid (ent_valid),
        .ent_size  (ent_size),
        .ent_vpn   (ent_vpn),
        .ent_pfn   (ent_pfn),
        .any_hit   (m_hit),
        .multi_hit (m_multi),
        .hit_idx   (m_idx),
        .pa        (m_pa)
    );

    // A hit counts as a use only when no flush occurs in the same cycle.
    assign use_hit = lk_valid && m_hit && !flush;

    tlb_lru_ranks #(
        .N_ENTRIES (N_ENTRIES)
    ) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .hit_en  (use_hit),
        .hit_idx (m_idx),
        .lru_idx (lru_index)
    );

    // Register the lookup result; a flush turns the lookup into a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_miss_trap <= 1'b0;
            rsp_multi_hit <= 1'b0;
            rsp_index     <= '0;
            rsp_pa        <= '0;
        end else begin
            rsp_valid     <= lk_valid;
            rsp_hit       <= use_hit;
            rsp_miss_trap <= lk_valid && !use_hit;
            rsp_multi_hit <= use_hit && m_multi;
            rsp_index     <= use_hit ? m_idx : '0;
            rsp_pa        <= use_hit ? m_pa  : '0;
        end
    end

    // R1: each request is answered exactly one cycle later.
    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R2: a response is either a hit or a miss, never both.
    a_r2_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss_trap));

    // R2: a miss reports a zero address and a zero index.
    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss_trap |-> (rsp_pa == '0 && rsp_index == '0));

    // R5: the multi-hit flag only appears together with a hit.
    a_r5_multi_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi_hit |-> rsp_hit);

    // R9: a lookup issued with a flush is answered as a miss.
    a_r9_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lk_valid) |=> rsp_miss_trap);

endmodule

// File: tb/tlb_sw_refill_tb_top.sv
// Scoreboard bench: the driver pushes the expected result of each cycle into
// a queue, and the monitor pops it just after the next rising edge.
module tlb_sw_refill_tb_top;

    localparam int N   = 64;
    localparam int IW  = $clog2(N);
    localparam int VAW = 32;
    localparam int PAW = 32;

    typedef struct {
        bit          rv;
        bit          hit;
        bit          miss;
        bit          multi;
        int          idx;
        logic [31:0] pa;
        int          lru;
        string       tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VAW-1:0]   lk_va = '0;
    logic             wr_en = 1'b0;
    logic [IW-1:0]    wr_index = '0;
    logic             wr_valid = 1'b0;
    logic [3:0]       wr_size = '0;
    logic [VAW-14:0]  wr_vpn = '0;
    logic [PAW-14:0]  wr_pfn = '0;
    logic             rsp_valid, rsp_hit, rsp_miss_trap, rsp_multi_hit;
    logic [IW-1:0]    rsp_index, lru_index;
    logic [PAW-1:0]   rsp_pa;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    exp_t q[$];

    // Model state: entry contents and the recency list, least recent first.
    bit          m_valid [N];
    int          m_size  [N];
    logic [18:0] m_vpn   [N];
    logic [18:0] m_pfn   [N];
    int          order[$];

    always #4 clk = ~clk;

    tlb_sw_refill #(.N_ENTRIES(N), .VA_W(VAW), .PA_W(PAW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_va(lk_va),
        .wr_en(wr_en), .wr_index(wr_index), .wr_valid(wr_valid), .wr_size(wr_size),
        .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_miss_trap(rsp_miss_trap), .rsp_multi_hit(rsp_multi_hit),
        .rsp_index(rsp_index), .rsp_pa(rsp_pa), .lru_index(lru_index)
    );

    task automatic model_reset();
        order.delete();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0;
            order.push_back(i);
        end
    endtask

    task automatic model_touch(input int h);
        for (int k = 0; k < order.size(); k++)
            if (order[k] == h) begin
                order.delete(k);
                break;
            end
        order.push_back(h);
    endtask

    // Drive one cycle and push the result expected for it.
    task automatic step(input bit lv, input logic [31:0] va, input bit we, input int widx,
                        input bit wv, input int ws, input logic [18:0] wvpn,
                        input logic [18:0] wpfn, input bit fl, input string tag);
        exp_t e;
        int   hits;
        @(negedge clk);
        lk_valid = lv; lk_va = va; wr_en = we; wr_index = IW'(widx); wr_valid = wv;
        wr_size = 4'(ws); wr_vpn = wvpn; wr_pfn = wpfn; flush = fl;
        e.rv = lv; e.hit = 0; e.miss = 0; e.multi = 0; e.idx = 0; e.pa = '0; e.tag = tag;
        hits = 0;
        if (lv && !fl) begin
            for (int i = 0; i < N; i++) begin
                int sh;
                sh = 13 + m_size[i];
                if (m_valid[i] && ((va >> sh) == ({13'b0, m_vpn[i]} >> m_size[i]))) begin
                    if (hits == 0) begin
                        e.idx = i;
                        e.pa  = ((32'({m_pfn[i], 13'b0}) >> sh) << sh) |
                                (va & ((32'd1 << sh) - 32'd1));
                    end
                    hits++;
                end
            end
        end
        if (lv) begin
            e.hit = (hits > 0); e.miss = (hits == 0); e.multi = (hits > 1);
        end
        if (fl) begin
            model_reset();
        end else begin
            if (e.hit) model_touch(e.idx);
            if (we) begin
                m_valid[widx] = wv;
                m_size[widx]  = (ws > 11) ? 11 : ws;
                m_vpn[widx]   = wvpn;
                m_pfn[widx]   = wpfn;
            end
        end
        e.lru = order[0];
        q.push_back(e);
    endtask

    task automatic look(input logic [31:0] va, input string tag);
        step(1, va, 0, 0, 0, 0, '0, '0, 0, tag);
    endtask

    task automatic wr(input int idx, input bit v, input int s, input logic [18:0] vpn,
                      input logic [18:0] pfn, input string tag);
        step(0, '0, 1, idx, v, s, vpn, pfn, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, 0, 0, 0, '0, '0, 0, tag);
    endtask

    // Monitor: compare every cycle's result just after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                bit bad;
                e = q.pop_front();
                n_checks++;
                bad = (rsp_valid !== e.rv) || (int'(lru_index) != e.lru);
                if (e.rv)
                    bad = bad || (rsp_hit !== e.hit) || (rsp_miss_trap !== e.miss) ||
                          (rsp_multi_hit !== e.multi) || (int'(rsp_index) != e.idx) ||
                          (rsp_pa !== e.pa);
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: got v=%0b h=%0b m=%0b mh=%0b idx=%0d pa=%h lru=%0d; exp v=%0b h=%0b m=%0b mh=%0b idx=%0d pa=%h lru=%0d",
                             e.tag, rsp_valid, rsp_hit, rsp_miss_trap, rsp_multi_hit,
                             rsp_index, rsp_pa, lru_index, e.rv, e.hit, e.miss, e.multi,
                             e.idx, e.pa, e.lru);
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        for (int i = 0; i < N; i++) begin
            m_size[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0;
        end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        n_checks++;
        if (rsp_valid !== 1'b0 || lru_index !== '0) begin
            n_fail++;
            $display("FAIL R10 reset: got v=%0b lru=%0d, exp v=0 lru=0", rsp_valid, lru_index);
        end
        @(negedge clk);
        rst_n = 1'b1;

        look(32'h1234_5678, "R10 empty after reset -> R2 miss");
        // R4 R1: write then hit on an 8 KB page; R7: the write leaves lru at 0
        wr(5, 1, 0, 19'h12345, 19'h00abc, "R7 write no lru change");
        look({19'h12345, 13'h0123}, "R1 hit 8KB");
        look({19'h12346, 13'h0123}, "R2 neighbour page miss");
        // R6: hitting entry 0 moves the candidate to entry 1
        wr(0, 1, 0, 19'h00010, 19'h00020, "R4 write entry 0");
        look({19'h00010, 13'h1fff}, "R6 hit entry 0 ages");
        look({19'h00010, 13'h0000}, "R6 second hit entry 0");
        // R3: 16 MB page; offset bits 23:0 pass through
        wr(1, 1, 11, 19'h7f800, 19'h40000, "R3 write 16MB");
        look(32'hFF12_3456, "R3 16MB hit");
        look(32'hFE12_3456, "R3 16MB out of page miss");
        // R3: code 15 acts as code 11
        wr(3, 1, 15, 19'h08000, 19'h10000, "R3 write code 15");
        look(32'h10AB_CDEF, "R3 clamp code 15");
        // R3: mid size (code 4, 128 KB)
        wr(4, 1, 4, 19'h20010, 19'h30000, "R3 write 128KB");
        look({19'h2001f, 13'h0abc}, "R3 128KB hit");
        // R4: an invalid entry never matches
        wr(6, 0, 0, 19'h55555, 19'h11111, "R4 write invalid");
        look({19'h55555, 13'h0}, "R4 invalid no match");
        // R5: entries 2 and 7 both map the same page; lowest index wins
        wr(7, 1, 0, 19'h33333, 19'h07777, "R5 write 7");
        wr(2, 1, 0, 19'h33333, 19'h02222, "R5 write 2");
        look({19'h33333, 13'h0042}, "R5 multi-hit lowest");
        // R8: rewrite entry 5 in the same cycle as a lookup of its old page
        step(1, {19'h12345, 13'h0007}, 1, 5, 1, 0, 19'h54321, 19'h00def, 0, "R8 old contents hit");
        look({19'h12345, 13'h0007}, "R8 old page gone");
        look({19'h54321, 13'h0007}, "R8 new page hit");
        // R9: a lookup and a write together with a flush
        step(1, {19'h54321, 13'h0}, 1, 9, 1, 0, 19'h00099, 19'h00099, 1, "R9 flush lookup miss");
        look({19'h00099, 13'h0}, "R9 write dropped in flush");
        look({19'h33333, 13'h0}, "R9 flushed entries miss");
        idle("R7 idle lru stable");
        // R6: fill every entry, then hit in random and sequential orders
        for (int i = 0; i < N; i++)
            wr(i, 1, 0, 19'(i + 256), 19'(i + 1024), "R4 fill");
        for (int k = 0; k < 300; k++) begin
            int t;
            t = $urandom_range(N - 1);
            look({19'(t + 256), 13'(k)}, "R6 random hit order");
        end
        for (int i = 0; i < N; i++)
            look({19'(i + 256), 13'h0}, "R6 sequential sweep");
        look(32'h0000_0000, "R7 miss leaves order");
        wr(0, 1, 0, 19'h00123, 19'h00456, "R7 refill at candidate");
        look({19'h00123, 13'h0}, "R6 refilled entry hit");
        idle("drain");
        idle("drain");
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule